// File: doc/BRIEF.md
# Seconds Prescaler with External Test Clock

This block turns a slow timing tick into a seconds increment. A six-stage binary chain counts the rising events of its selected source and raises a one-cycle `sec_pulse` each time bit 5 of the chain goes from 0 to 1. In normal operation the source is a 64 Hz tick that arrives as a one-cycle strobe in the system clock domain. When `test_mode` is set, the source is the rising edges of an asynchronous pin. The pin is brought into the clock domain by a two-flop synchronizer and then edge-detected. Test equipment can therefore advance the seconds much faster than real time.

A `stop` input holds the whole chain at zero. Entering test mode is not aligned to the chain's state, so the intended sequence is this: select test mode, pulse `stop`, release it, and then drive edges. After the release, the first seconds pulse follows the 32nd rising edge, and every later pulse follows 64 more edges. The calendar counters that consume `sec_pulse` are outside this block.

Top module: `sec_prescaler`

## Requirements
- R1: After synchronous reset, `sec_pulse` is 0, the chain is cleared and the internal tick is the source, so the first pulse follows the 32nd internal tick after reset.
- R2: With `test_mode` at 0, the first `sec_pulse` after a clear follows the 32nd `tick_in` strobe, and each further pulse follows 64 more strobes.
- R3: Every `sec_pulse` is high for exactly one clock cycle.
- R4: With `test_mode` at 1, only 0-to-1 transitions of `ext_pin` advance the chain, with the same 32-then-64 spacing as R2; falling transitions do not count.
- R5: With `test_mode` at 1, `tick_in` strobes have no effect on the chain.
- R6: With `test_mode` at 0, transitions of `ext_pin` have no effect on the chain.
- R7: While `stop` is 1, the chain is held at zero and `sec_pulse` stays 0. After release, the first pulse follows the 32nd source edge.
- R8: When `stop` is 1 in the same cycle as the edge that would complete the count, `stop` wins: no pulse is produced and the chain restarts from zero.
- R9: `sec_pulse` is registered. It is high in the cycle after the clock edge that samples the completing `tick_in` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Internal 64 Hz tick, one-cycle strobe |
| test_mode | input | 1 | 1 selects the external pin as the source |
| ext_pin | input | 1 | Asynchronous external test clock pin |
| stop | input | 1 | 1 holds the chain at zero |
| sec_pulse | output | 1 | One-cycle seconds increment |

## Verification
The two functions that can meet in one cycle are the hold from `stop` and the source edge that completes the 32-count. The bench clears the chain and drives 31 internal strobes. It then raises `tick_in` and `stop` in the same cycle. It judges the result by the absence of any pulse, and then by counting how many further strobes are needed before the next pulse: 32 confirms that the chain was restarted rather than advanced. The table walk also confirms that each source is ignored while the other one is selected.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_sel_e;
  localparam int DEF_DIV_BITS    = 6;
  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/sp_pin_sync.sv
module sp_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= pin;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sp_src_mux.sv
module sp_src_mux
  import sp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic test_mode,
  input  logic tick_in,
  input  logic ext_rise,
  output logic adv
);
  src_sel_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= SRC_INT;
    else     mode_q <= test_mode ? SRC_EXT : SRC_INT;
  end

  assign adv = (mode_q == SRC_EXT) ? ext_rise : tick_in;
endmodule

// File: rtl/sp_div_chain.sv
module sp_div_chain #(
  parameter int BITS = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stop,
  input  logic            adv,
  output logic [BITS-1:0] cnt,
  output logic            pulse
);
  // the count just below the moment the top bit turns on
  localparam logic [BITS-1:0] HALF_M1 = {1'b0, {(BITS-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= adv && (cnt == HALF_M1);
      if (adv) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
  import sp_pkg::*;
#(
  parameter int DIV_BITS    = DEF_DIV_BITS,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  input  logic test_mode,
  input  logic ext_pin,
  input  logic stop,
  output logic sec_pulse
);
  logic                ext_rise;
  logic                adv;
  logic [DIV_BITS-1:0] cnt;

  sp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_pin),
    .rise (ext_rise)
  );

  sp_src_mux u_mux (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .tick_in   (tick_in),
    .ext_rise  (ext_rise),
    .adv       (adv)
  );

  sp_div_chain #(.BITS(DIV_BITS)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .stop  (stop),
    .adv   (adv),
    .cnt   (cnt),
    .pulse (sec_pulse)
  );
endmodule

// File: rtl/sec_prescaler_chk.sv
module sp_checker #(
  parameter int BITS = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            stop,
  input logic            adv,
  input logic [BITS-1:0] cnt,
  input logic            sec_pulse
);
  localparam logic [BITS-1:0] HALF = {1'b1, {(BITS-1){1'b0}}};

  a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |=> !sec_pulse);

  a_r7_stop_holds: assert property (@(posedge clk) disable iff (rst)
    stop |=> (cnt == '0) && !sec_pulse);

  a_r2_pulse_at_half: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |-> (cnt == HALF));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (!stop && adv) |=> (cnt == $past(cnt) + 1'b1));

  a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!stop && !adv) |=> $stable(cnt));

  a_r8_stop_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (stop && adv) |=> !sec_pulse);
endmodule

bind sec_prescaler sp_checker #(.BITS(DIV_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stop      (stop),
  .adv       (adv),
  .cnt       (cnt),
  .sec_pulse (sec_pulse)
);

// File: tb/sec_prescaler_tb.sv
`timescale 1ns/1ps
module sec_prescaler_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_in = 1'b0;
  logic test_mode = 1'b0;
  logic ext_pin = 1'b0;
  logic stop = 1'b0;
  logic sec_pulse;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int run = 0;
  int max_run = 0;

  always #2.5 clk = ~clk;

  sec_prescaler u_dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .test_mode(test_mode),
    .ext_pin(ext_pin), .stop(stop), .sec_pulse(sec_pulse)
  );

  always @(negedge clk) begin
    if (sec_pulse) begin
      pulses++;
      run++;
      if (run > max_run) max_run = run;
    end else begin
      run = 0;
    end
  end

  // table: source (0 internal, 1 pin), edge count, pulses expected after a clear
  localparam int NV = 8;
  localparam int VSRC [NV] = '{0, 0, 0, 0, 0, 1, 1, 1};
  localparam int VN   [NV] = '{31, 32, 95, 96, 160, 31, 32, 96};
  localparam int VEXP [NV] = '{0, 1, 1, 2, 3, 0, 1, 2};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick_in = 1'b1;
      @(posedge clk); #1 tick_in = 1'b0;
    end
  endtask

  task automatic pin_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 ext_pin = 1'b1;
      repeat (4) @(posedge clk);
      #1 ext_pin = 1'b0;
      repeat (4) @(posedge clk);
    end
  endtask

  task automatic clear_chain(input logic mode);
    @(posedge clk); #1 test_mode = mode;
    repeat (3) @(posedge clk);
    #1 stop = 1'b1;
    repeat (2) @(posedge clk);
    #1 stop = 1'b0;
  endtask

  task automatic settle;
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pulse low in reset", int'(sec_pulse), 0);
    @(posedge clk); #1 rst = 1'b0;

    // R1: first pulse after 32 ticks from reset
    base = pulses;
    ticks(31); settle;
    check("R1 no pulse after 31 ticks", pulses - base, 0);
    ticks(1); settle;
    check("R1 pulse after 32 ticks", pulses - base, 1);

    // table walk: R2, R4, R7
    for (int v = 0; v < NV; v++) begin
      clear_chain(VSRC[v] != 0);
      base = pulses;
      if (VSRC[v] != 0) pin_edges(VN[v]);
      else ticks(VN[v]);
      settle;
      check(VSRC[v] != 0 ? "R4 pin edge spacing" : "R2 R7 tick spacing",
            pulses - base, VEXP[v]);
    end

    // R7: held stop blocks counting
    @(posedge clk); #1 test_mode = 1'b0; stop = 1'b1;
    base = pulses;
    ticks(100); settle;
    check("R7 no pulse while stop", pulses - base, 0);
    @(posedge clk); #1 stop = 1'b0;
    ticks(32); settle;
    check("R7 first pulse after release", pulses - base, 1);

    // R5: ticks ignored in test mode
    clear_chain(1'b1);
    base = pulses;
    pin_edges(31);
    ticks(40); settle;
    check("R5 ticks ignored in test mode", pulses - base, 0);
    pin_edges(1); settle;
    check("R5 pin count unchanged by ticks", pulses - base, 1);

    // R6: pin ignored in internal mode
    clear_chain(1'b0);
    base = pulses;
    ticks(31);
    pin_edges(40); settle;
    check("R6 pin ignored in internal mode", pulses - base, 0);
    ticks(1); settle;
    check("R6 tick count unchanged by pin", pulses - base, 1);

    // R9 and R3: exact cycle of the pulse
    clear_chain(1'b0);
    ticks(31);
    @(posedge clk); #1 tick_in = 1'b1;
    @(negedge clk);
    check("R9 no pulse before sampling edge", int'(sec_pulse), 0);
    @(posedge clk); #1 tick_in = 1'b0;
    @(negedge clk);
    check("R9 pulse one cycle after strobe", int'(sec_pulse), 1);
    @(negedge clk);
    check("R3 pulse drops after one cycle", int'(sec_pulse), 0);

    // R8: stop meets the completing strobe in one cycle
    clear_chain(1'b0);
    base = pulses;
    ticks(31);
    @(posedge clk); #1 tick_in = 1'b1; stop = 1'b1;
    @(posedge clk); #1 tick_in = 1'b0; stop = 1'b0;
    settle;
    check("R8 stop wins over completing strobe", pulses - base, 0);
    ticks(31); settle;
    check("R8 chain restarted from zero", pulses - base, 0);
    ticks(1); settle;
    check("R8 pulse after 32 fresh ticks", pulses - base, 1);

    check("R3 longest pulse run", max_run, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule